// File: doc/BRIEF.md
# Fractional-Rate Pulse Enable Generator

This block produces a one-clock enable pulse whose average spacing is a rational, non-integer number of clock cycles, N/D. On every enabled clock a phase accumulator gains D. When the sum would reach N or more, N is taken off and a pulse is issued. The phase left over is kept, so gaps between pulses are always the floor or the ceiling of N/D, and the long-run rate is exactly D pulses per N cycles. It paces display line or pixel enables from a fast system clock, with no derived clock: the pulse is an enable in the same clock domain. For example, 480 pulses spread over 16,670,000 cycles give N = 208375 and D = 6.

The ratio can be given directly (`NUM`, `DEN`) or as a window form. In the window form the window length is a fraction `WIN_NUM/WIN_DEN` of time units, with `UNIT_CYC` cycles per unit, and `PULSES` pulses are wanted per window. The block then forms N = WIN_NUM·UNIT_CYC and D = WIN_DEN·PULSES, so both stay integers. With `REDUCE` set, N and D are divided by their greatest common divisor at elaboration time. This narrows the accumulator and leaves the rate unchanged. Illegal ratios (zero denominator, or one pulse or more per cycle) stop elaboration.

Top module: `frac_pace_gen`

## Requirements
- R1: Synchronous reset clears the phase to zero and holds `pulse` at 0. Counting only enabled cycles after reset, the first pulse follows enabled cycle number ceil(N/D).
- R2: Let k count the enabled cycles since reset. `pulse` is 1 in the cycle after enabled cycle k exactly when floor(k·D/N) > floor((k−1)·D/N), and 0 otherwise.
- R3: The distance between two consecutive pulses, counted in enabled cycles, is always floor(N/D) or ceil(N/D).
- R4: After every N enabled cycles counted from reset, exactly D pulses have been issued, so no drift builds up.
- R5: While `run` is 0 the phase is held and `pulse` is 0 in the following cycle. When `run` returns, the pulse sequence continues from the same phase.
- R6: `pulse` is registered and, for N/D ≥ 2, never stays high for two cycles in a row.
- R7: In the window form, the pulse sequence is identical to the one for N = WIN_NUM·UNIT_CYC and D = WIN_DEN·PULSES.
- R8: With `REDUCE` = 1, N and D are divided by their common divisor and the pulse sequence is unchanged, for example the first pulse of 100/12 and of 25/3 both follow enabled cycle 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance enable; when low the phase is frozen |
| pulse | output | 1 | Registered one-cycle pace pulse |

## Verification
Two events can fall on the same clock edge: a phase wrap that would fire a pulse, and `run` going low or `rst` being raised. The bench steers the phase to one cycle before a wrap and drops `run` there, then does the same with reset while `run` stays high. Random `run` patterns also land on wrap edges many times. In each case the pulse must be suppressed, and after a hold it must appear on the very next enabled cycle. After a reset it must come only after a fresh ceil(N/D) count, which the bench's closed-form floor model judges.

// File: rtl/frac_pace_pkg.sv
`timescale 1ns/1ps
package frac_pace_pkg;

   typedef longint unsigned u64_t;

   // greatest common divisor, zero-safe
   function automatic u64_t gcd_u64(input u64_t a, input u64_t b);
      u64_t x;
      u64_t y;
      u64_t t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // smallest w with 2**w >= v, at least 1
   function automatic int bits_for(input u64_t v);
      int w;
      w = 1;
      while (w < 63 && ((u64_t'(1) << w) < v)) w++;
      return w;
   endfunction

   typedef struct packed {
      u64_t num;
      u64_t den;
   } ratio_t;

   // choose direct or window-derived ratio, then optionally reduce
   function automatic ratio_t make_ratio(input u64_t num, input u64_t den,
                                         input u64_t win_num, input u64_t win_den,
                                         input u64_t unit_cyc, input u64_t pulses,
                                         input bit reduce);
      ratio_t r;
      u64_t   g;
      if (win_num != 0) begin
         r.num = win_num * unit_cyc;
         r.den = win_den * pulses;
      end else begin
         r.num = num;
         r.den = den;
      end
      g = reduce ? gcd_u64(r.num, r.den) : u64_t'(1);
      if (g == 0) g = 1;
      r.num = r.num / g;
      r.den = r.den / g;
      return r;
   endfunction

endpackage

// File: rtl/frac_phase_accum.sv
`timescale 1ns/1ps
module frac_phase_accum #(
   parameter longint unsigned N = 37,
   parameter longint unsigned D = 5,
   parameter int              W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run,
   output logic [W-1:0] acc_o,
   output logic         wrap_o
);
   localparam logic [W:0] D_V = D[W:0];
   localparam logic [W:0] N_V = N[W:0];

   logic [W-1:0] acc_q;
   logic [W:0]   sum;
   logic [W:0]   nxt;
   logic         wrap;

   always_comb begin
      sum  = {1'b0, acc_q} + D_V;
      wrap = (sum >= N_V);
      nxt  = wrap ? (sum - N_V) : sum;
   end

   always_ff @(posedge clk) begin
      if (rst)      acc_q <= '0;
      else if (run) acc_q <= nxt[W-1:0];
   end

   assign acc_o  = acc_q;
   assign wrap_o = wrap & run;
endmodule

// File: rtl/frac_pulse_reg.sv
`timescale 1ns/1ps
module frac_pulse_reg (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse_o
);
   logic q;
   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= fire;
   end
   assign pulse_o = q;
endmodule

// File: rtl/frac_pace_gen.sv
`timescale 1ns/1ps
module frac_pace_gen
   import frac_pace_pkg::*;
#(
   parameter longint unsigned NUM      = 208375,
   parameter longint unsigned DEN      = 6,
   parameter longint unsigned WIN_NUM  = 0,
   parameter longint unsigned WIN_DEN  = 1,
   parameter longint unsigned UNIT_CYC = 1,
   parameter longint unsigned PULSES   = 1,
   parameter bit              REDUCE   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic pulse
);
   localparam ratio_t          RAT   = make_ratio(NUM, DEN, WIN_NUM, WIN_DEN,
                                                  UNIT_CYC, PULSES, REDUCE);
   localparam longint unsigned N_EFF = RAT.num;
   localparam longint unsigned D_EFF = RAT.den;
   localparam int              ACC_W = bits_for(N_EFF + D_EFF);

   // elaboration-time legality checks
   if (D_EFF == 0) begin : g_bad_den
      $fatal(1, "frac_pace_gen: denominator is zero");
   end
   if (D_EFF >= N_EFF) begin : g_bad_rate
      $fatal(1, "frac_pace_gen: D must be below N");
   end
   if (ACC_W > 62) begin : g_bad_width
      $fatal(1, "frac_pace_gen: ratio too wide");
   end

   logic [ACC_W-1:0] acc_q;
   logic             wrap;

   frac_phase_accum #(.N(N_EFF), .D(D_EFF), .W(ACC_W)) u_accum (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .acc_o (acc_q),
      .wrap_o(wrap)
   );

   frac_pulse_reg u_preg (
      .clk    (clk),
      .rst    (rst),
      .fire   (wrap),
      .pulse_o(pulse)
   );
endmodule

// File: rtl/frac_pace_chk.sv
`timescale 1ns/1ps
module frac_pace_chk #(
   parameter longint unsigned N = 37,
   parameter longint unsigned D = 5,
   parameter int              W = 6
) (
   input logic         clk,
   input logic         rst,
   input logic         run,
   input logic         pulse,
   input logic [W-1:0] acc
);
   localparam longint unsigned LO = N / D;
   localparam longint unsigned HI = (N + D - 1) / D;
   localparam logic [W:0]      N_V = N[W:0];

   longint unsigned cnt;
   always_ff @(posedge clk) begin
      if (rst)        cnt <= 0;
      else if (pulse) cnt <= run ? 1 : 0;
      else if (run)   cnt <= cnt + 1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !pulse);
   assert_phase_below_n_R2: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, acc} < N_V));
   assert_gap_bounds_R3: assert property (@(posedge clk) disable iff (rst)
      pulse |-> (cnt == LO || cnt == HI));
   assert_idle_nopulse_R5: assert property (@(posedge clk) disable iff (rst)
      !run |=> !pulse);
   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(acc));
   assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
      (LO >= 2 && pulse) |=> !pulse);
endmodule

bind frac_pace_gen frac_pace_chk #(.N(N_EFF), .D(D_EFF), .W(ACC_W)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .run  (run),
   .pulse(pulse),
   .acc  (acc_q)
);

// File: tb/test_frac_pace_gen.sv
`timescale 1ns/1ps
module test_frac_pace_gen;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run = 1'b0;
   logic pulse_a;
   logic pulse_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   // A: direct 37/5. B: window 50/3 units, 2 cycles/unit, 4 pulses -> 100/12 -> 25/3
   frac_pace_gen #(.NUM(37), .DEN(5)) i_frac_pace_gen (
      .clk(clk), .rst(rst), .run(run), .pulse(pulse_a));
   frac_pace_gen #(.WIN_NUM(50), .WIN_DEN(3), .UNIT_CYC(2), .PULSES(4), .REDUCE(1'b1))
      i_frac_pace_gen_win (.clk(clk), .rst(rst), .run(run), .pulse(pulse_b));

   localparam longint NA = 37,  DA = 5;
   localparam longint NB = 100, DB = 12;  // raw window ratio

   function automatic bit exp_pulse(longint k, longint n, longint d);
      if (k <= 0) return 1'b0;
      return ((k * d) / n) != (((k - 1) * d) / n);
   endfunction

   function automatic longint ceil_div(longint n, longint d);
      return (n + d - 1) / d;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   longint k = 0;
   longint last_a = 0, last_b = 0;
   longint cnt_a = 0;
   bit     prev_a = 0;

   // one clock: drive run, count edge, sample at negedge
   task automatic step(bit r);
      bit ea, eb;
      run = r;
      @(posedge clk);
      if (r) k++;
      @(negedge clk);
      ea = r && exp_pulse(k, NA, DA);
      eb = r && exp_pulse(k, NB, DB);
      chk(pulse_a == ea, "R2 rate A", pulse_a, ea);
      chk(pulse_b == eb, "R7 window B", pulse_b, eb);
      if (!r) chk(pulse_a == 0 && pulse_b == 0, "R5 idle", pulse_a, 0);
      if (prev_a) chk(pulse_a == 0, "R6 single", pulse_a, 0);
      prev_a = pulse_a;
      if (pulse_a) begin
         if (last_a == 0) chk(k == ceil_div(NA, DA), "R1 first A", k, ceil_div(NA, DA));
         else chk((k - last_a) == NA / DA || (k - last_a) == ceil_div(NA, DA),
                  "R3 gap A", k - last_a, NA / DA);
         last_a = k;
         cnt_a++;
      end
      if (pulse_b) begin
         if (last_b == 0) chk(k == 9, "R8 first B reduced", k, 9);
         else chk((k - last_b) == 8 || (k - last_b) == 9, "R3 gap B", k - last_b, 8);
         last_b = k;
      end
      if (r && k > 0 && (k % NA) == 0)
         chk(cnt_a == (k / NA) * DA, "R4 drift A", cnt_a, (k / NA) * DA);
   endtask

   task automatic do_reset(bit r);
      rst = 1'b1;
      run = r;
      repeat (3) begin
         @(posedge clk);
         @(negedge clk);
         chk(pulse_a == 0 && pulse_b == 0, "R1 reset", pulse_a, 0);
      end
      rst = 1'b0;
      k = 0; last_a = 0; last_b = 0; cnt_a = 0; prev_a = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(1'b0);
      // directed: free run through first pulses
      repeat (40) step(1'b1);
      // park one cycle before a wrap of A, hold run low there
      while (!exp_pulse(k + 1, NA, DA)) step(1'b1);
      repeat (7) step(1'b0);
      step(1'b1);   // R5: resumes with the pending pulse
      chk(pulse_a == 1, "R5 resume", pulse_a, 1);
      // reset landing on a wrap edge with run high
      while (!exp_pulse(k + 1, NA, DA)) step(1'b1);
      do_reset(1'b1);
      // random run patterns
      for (int i = 0; i < 4000; i++) step(($urandom % 4) != 0);
      repeat (200) step(1'b1);
      for (int i = 0; i < 1500; i++) step(($urandom % 8) == 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20ns * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule